// File: doc/BRIEF.md
# Variable-Degree Reseedable Pattern Expander

This block expands compact seeds into scan-chain fill data. It holds a linear feedback shift register whose feedback polynomial is taken from a small parameter table of up to four entries, and each entry may have a different degree. Sparse test cubes are encoded with a short polynomial and dense ones with a long one, so every seed is only as long as its own polynomial's degree.

A tester asserts `start_i` while the block is idle. The block then takes seed bits serially over a valid/ready handshake, and the number of bits it takes equals the degree of the active polynomial. To track the load, a marker register is filled with one bit per stage of the active span. It drains by one bit for every accepted seed bit, and loading ends when it is empty. One more bit follows the seed. When that bit is set, the next expansion uses the next table entry, and the index wraps to the first entry after the last. The register then free-runs for a fixed number of cycles and emits one scan bit per cycle, and `done_o` pulses once at the end.

The table is a parameter. Each entry is a tap vector whose highest set bit marks the degree. The feedback polynomials themselves and the seed values are computed outside this block.

Top module: `varpoly_expander`

## Requirements
- R1: After reset the block is idle: `seed_ready_o`, `scan_valid_o` and `done_o` are low, and the first expansion uses table entry 0.
- R2: `start_i` begins an expansion only while the block is idle. A `start_i` seen during loading or running has no effect, and `seed_ready_o` stays low after the following `done_o`.
- R3: For a table entry whose highest set bit is at position m-1, exactly m seed bits and then one switch-flag bit are accepted (valid and ready high at the same rising edge) before the first scan bit. Cycles with `seed_valid_i` low do not count.
- R4: The first accepted seed bit ends up in stage m-1 and the last in stage 0. Stages at or above m always hold 0, so table bits above the degree never reach the feedback.
- R5: While running, `scan_bit_o` is stage m-1. At each cycle the register shifts toward higher stages, and stage 0 takes the XOR of all stages whose tap bit is 1.
- R6: `scan_valid_o` is high for exactly RUN_LEN consecutive cycles. `done_o` is high for a single cycle, the one right after the last scan cycle.
- R7: A switch flag of 1 moves the next expansion to the next table entry, wrapping from NUM_POLY-1 to 0. A flag of 0 keeps the same entry.
- R8: `seed_ready_o` is low whenever the block is not loading a seed or waiting for the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an expansion (used only while idle) |
| seed_bit_i | input | 1 | Serial seed bit, or the switch flag after the seed |
| seed_valid_i | input | 1 | `seed_bit_i` is valid |
| seed_ready_o | output | 1 | Block accepts a serial bit this cycle |
| scan_bit_o | output | 1 | Scan fill data |
| scan_valid_o | output | 1 | `scan_bit_o` is valid |
| done_o | output | 1 | One-cycle pulse after the last scan bit |

## Verification
Directed cubes step through every table entry in order: degree 5, 8, 12 and 16, then a wrap back to 5. The accepted-bit count checks that each degree sets its own seed length, and the flag that follows moves the next cube to the next entry. An all-zero seed must give an all-zero scan stream. An all-ones seed with the widest entry exercises every tap, and a seed with high bits set under a short entry shows that stages above the degree stay out of the feedback. Random seeds, random flags and random gaps in `seed_valid_i` separate a correct handshake count and feedback recurrence from one that counts cycles rather than transfers. A `start_i` pulse in the middle of a run checks that the block does not restart.

// File: rtl/vpx_pkg.sv
package vpx_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LOAD,
        PH_FLAG,
        PH_RUN,
        PH_DONE
    } phase_e;
endpackage

// File: rtl/poly_store.sv
module poly_store #(
    parameter int MAX_DEG  = 16,
    parameter int NUM_POLY = 4,
    parameter int SELW     = 2,
    parameter logic [NUM_POLY*MAX_DEG-1:0] POLY_SET = '0
) (
    input  logic [SELW-1:0]    sel_i,
    output logic [MAX_DEG-1:0] word_o
);
    logic [MAX_DEG-1:0] words [NUM_POLY];

    for (genvar g = 0; g < NUM_POLY; g++) begin : g_word
        assign words[g] = POLY_SET[g*MAX_DEG +: MAX_DEG];
    end

    always_comb begin
        word_o = '0;
        for (int i = 0; i < NUM_POLY; i++) begin
            if (int'(sel_i) == i) word_o = words[i];
        end
    end
endmodule

// File: rtl/tap_decoder.sv
module tap_decoder #(
    parameter int MAX_DEG = 16
) (
    input  logic [MAX_DEG-1:0] raw_i,
    output logic [MAX_DEG-1:0] taps_o,
    output logic [MAX_DEG-1:0] span_o,
    output logic [MAX_DEG-1:0] head_o
);
    localparam int TW = $clog2(MAX_DEG);

    logic [TW-1:0] top_d;

    always_comb begin
        top_d = '0;
        for (int i = 0; i < MAX_DEG; i++) begin
            if (raw_i[i]) top_d = TW'(i);
        end
    end

    always_comb begin
        for (int i = 0; i < MAX_DEG; i++) begin
            span_o[i] = (i <= int'(top_d));
            head_o[i] = (i == int'(top_d));
        end
        taps_o = raw_i & span_o;
    end
endmodule

// File: rtl/fill_marker.sv
module fill_marker #(
    parameter int MAX_DEG = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arm_i,
    input  logic [MAX_DEG-1:0] span_i,
    input  logic               shift_i,
    output logic               empty_o
);
    logic [MAX_DEG-1:0] marker_d, marker_q;

    always_comb begin
        marker_d = marker_q;
        if (arm_i)        marker_d = span_i;
        else if (shift_i) marker_d = marker_q >> 1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) marker_q <= '0;
        else        marker_q <= marker_d;
    end

    assign empty_o = (marker_q == '0);

    // R3: each accepted seed bit drains exactly one marker bit
    p_marker_drain_r3: assert property (@(posedge clk) disable iff (!rst_n)
        shift_i |=> marker_q == ($past(marker_q) >> 1));

    // R3: arming loads one marker bit per stage of the active span
    p_marker_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> $countones(marker_q) == $countones($past(span_i)));
endmodule

// File: rtl/varpoly_expander.sv
module varpoly_expander #(
    parameter int MAX_DEG  = 16,
    parameter int NUM_POLY = 4,
    parameter int RUN_LEN  = 20,
    parameter logic [NUM_POLY*MAX_DEG-1:0] POLY_SET =
        {16'hB400, 16'h0E08, 16'h00B8, 16'h0014}
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic seed_bit_i,
    input  logic seed_valid_i,
    output logic seed_ready_o,
    output logic scan_bit_o,
    output logic scan_valid_o,
    output logic done_o
);
    import vpx_pkg::*;

    localparam int SELW = (NUM_POLY > 1) ? $clog2(NUM_POLY) : 1;
    localparam int CNTW = $clog2(RUN_LEN + 1);

    typedef struct packed {
        phase_e             ph;
        logic [MAX_DEG-1:0] lfsr;
        logic [SELW-1:0]    sel;
        logic               sw;
        logic [CNTW-1:0]    cnt;
    } state_t;

    state_t q, d;

    logic [MAX_DEG-1:0] raw, taps, span, head;
    logic               mk_empty, mk_arm, mk_shift;

    poly_store #(
        .MAX_DEG (MAX_DEG),
        .NUM_POLY(NUM_POLY),
        .SELW    (SELW),
        .POLY_SET(POLY_SET)
    ) u_store (
        .sel_i (q.sel),
        .word_o(raw)
    );

    tap_decoder #(.MAX_DEG(MAX_DEG)) u_dec (
        .raw_i (raw),
        .taps_o(taps),
        .span_o(span),
        .head_o(head)
    );

    fill_marker #(.MAX_DEG(MAX_DEG)) u_mark (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm_i  (mk_arm),
        .span_i (span),
        .shift_i(mk_shift),
        .empty_o(mk_empty)
    );

    assign mk_arm   = (q.ph == PH_IDLE) && start_i;
    assign mk_shift = (q.ph == PH_LOAD) && !mk_empty && seed_valid_i;

    always_comb begin
        d = q;
        case (q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    d.ph   = PH_LOAD;
                    d.lfsr = '0;
                end
            end
            PH_LOAD: begin
                if (mk_empty) begin
                    d.ph = PH_FLAG;
                end else if (seed_valid_i) begin
                    d.lfsr = {q.lfsr[MAX_DEG-2:0], seed_bit_i} & span;
                end
            end
            PH_FLAG: begin
                if (seed_valid_i) begin
                    d.sw  = seed_bit_i;
                    d.cnt = '0;
                    d.ph  = PH_RUN;
                end
            end
            PH_RUN: begin
                d.lfsr = {q.lfsr[MAX_DEG-2:0], ^(q.lfsr & taps)} & span;
                d.cnt  = q.cnt + 1'b1;
                if (q.cnt == CNTW'(RUN_LEN - 1)) d.ph = PH_DONE;
            end
            PH_DONE: begin
                d.lfsr = '0;
                if (q.sw) begin
                    d.sel = (q.sel == SELW'(NUM_POLY - 1)) ? '0 : q.sel + 1'b1;
                end
                d.sw = 1'b0;
                d.ph = PH_IDLE;
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{ph: PH_IDLE, default: '0};
        else        q <= d;
    end

    assign seed_ready_o = ((q.ph == PH_LOAD) && !mk_empty) || (q.ph == PH_FLAG);
    assign scan_bit_o   = |(q.lfsr & head);
    assign scan_valid_o = (q.ph == PH_RUN);
    assign done_o       = (q.ph == PH_DONE);

    // R4: stages at or above the active degree stay clear
    p_upper_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.lfsr & ~span) == '0);

    // R5: stage 0 takes the parity of the tapped stages while running
    p_feedback_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_RUN) |=> q.lfsr[0] == ^($past(q.lfsr) & $past(taps)));

    // R6: done is a single-cycle pulse that follows a scan cycle
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_done_after_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(scan_valid_o));

    // R2: loading is entered only from idle
    p_start_only_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph != PH_IDLE && q.ph != PH_LOAD) |=> q.ph != PH_LOAD);

    // R7: the table index moves by one step with wrap, or not at all
    p_sel_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sel != $past(q.sel)) |->
            q.sel == (($past(q.sel) == SELW'(NUM_POLY - 1)) ? '0 : $past(q.sel) + 1'b1));

    // R8: no serial bits are requested while running
    p_no_ready_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        scan_valid_o |-> !seed_ready_o);
endmodule

// File: tb/sim_varpoly_expander.sv
module sim_varpoly_expander;
    localparam int K = 16;
    localparam int L = 20;

    logic clk = 1'b0;
    logic rst_n, start, sbit, svalid;
    logic sready, scan_bit, scan_valid, done;

    always #5 clk = ~clk;

    varpoly_expander #(.MAX_DEG(K), .NUM_POLY(4), .RUN_LEN(L)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .seed_bit_i(sbit), .seed_valid_i(svalid),
        .seed_ready_o(sready), .scan_bit_o(scan_bit),
        .scan_valid_o(scan_valid), .done_o(done)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int cur    = 0;

    function automatic logic [K-1:0] poly_of(int idx);
        case (idx)
            0: return 16'h0014;
            1: return 16'h00B8;
            2: return 16'h0E08;
            default: return 16'hB400;
        endcase
    endfunction

    function automatic int deg_of(int idx);
        case (idx)
            0: return 5;
            1: return 8;
            2: return 12;
            default: return 16;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_cube(input logic [K-1:0] seed, input bit flag,
                            input bit stall, input bit poke);
        int m        = deg_of(cur);
        logic [K-1:0] poly = poly_of(cur);
        logic [K-1:0] mask = (K'(1) << m) - 1'b1;
        logic [K-1:0] s    = '0;
        int acc   = 0;
        int guard = 0;
        int runs  = 0;
        int bad   = 0;
        int first_act = 0;
        int first_exp = 0;
        for (int i = 0; i < m; i++) s = ((s << 1) | K'(seed[i])) & mask;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (!scan_valid && guard < 200) begin
            if (sready && !(stall && ($urandom % 3 == 0))) begin
                svalid = 1'b1;
                sbit   = (acc < m) ? seed[acc] : flag;
                acc++;
            end else begin
                svalid = 1'b0;
                sbit   = 1'b0;
            end
            @(negedge clk);
            guard++;
        end
        svalid = 1'b0;
        // R3: seed length follows the active degree, plus one flag bit
        check(acc == m + 1, "R3", "accepted serial bits", acc, m + 1);
        while (scan_valid && runs < L + 5) begin
            logic e = s[m-1];
            if (scan_bit !== e && bad == 0) begin
                first_act = int'(scan_bit);
                first_exp = int'(e);
            end
            if (scan_bit !== e) bad++;
            s = ((s << 1) | K'(^(s & poly))) & mask;
            runs++;
            start = poke && (runs == 3);
            // R8: no request for bits while running
            if (runs == 2) check(!sready, "R8", "ready during run", sready, 0);
            @(negedge clk);
        end
        start = 1'b0;
        // R5: scan stream matches the recurrence from the loaded seed (R4 order)
        check(bad == 0, "R5", "first mismatching scan bit", first_act, first_exp);
        // R6: run length and done timing
        check(runs == L, "R6", "scan valid cycles", runs, L);
        check(done == 1'b1, "R6", "done after last scan", done, 1);
        @(negedge clk);
        check(done == 1'b0, "R6", "done pulse width", done, 0);
        // R2: a start during the run did not restart the block
        check(!sready && !scan_valid, "R2", "idle after done", sready, 0);
        if (flag) cur = (cur + 1) % 4;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; start = 1'b0; sbit = 1'b0; svalid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!sready, "R1", "ready after reset", sready, 0);
        check(!scan_valid, "R1", "scan valid after reset", scan_valid, 0);
        check(!done, "R1", "done after reset", done, 0);

        // R7: walk all entries and wrap; R1 first cube uses entry 0
        run_cube(16'h0015, 1'b0, 1'b0, 1'b0);
        run_cube(16'hFFE9, 1'b1, 1'b0, 1'b0);   // R4: high seed bits beyond degree 5
        run_cube(16'h00A7, 1'b1, 1'b0, 1'b0);
        run_cube(16'h0C3D, 1'b1, 1'b0, 1'b0);
        run_cube(16'hFFFF, 1'b1, 1'b0, 1'b1);   // all ones, widest, start poke (R2)
        run_cube(16'h0000, 1'b0, 1'b0, 1'b0);   // wrapped to degree 5, zero seed
        run_cube(16'h0013, 1'b0, 1'b1, 1'b1);   // stalls in valid

        for (int r = 0; r < 24; r++) begin
            logic [K-1:0] sd = K'($urandom);
            bit fl = ($urandom % 2) == 1;
            bit st = ($urandom % 2) == 1;
            bit pk = ($urandom % 4) == 0;
            run_cube(sd, fl, st, pk);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule